// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block produces the active-low control strobes for a single chip select of an asynchronous static-memory port. A requester raises a one-cycle start request together with a direction bit. The block then runs one access and ends it with a done pulse. During the access it drives a read strobe or a write strobe, together with the chip-select strobe. Each strobe falls after its own programmed delay and stays low for its own programmed width. The access ends after a programmed total length.

Every timing value arrives in a compact code. In that code the high bits add a large coarse offset and the low bits add a fine count. The block keeps two setup/width pairs for reads: one for the read strobe and one for the chip select. It keeps two more pairs for writes: one for the write strobe and one for the chip select. It also keeps a separate total length for reads and for writes. At acceptance the block decodes the set that the direction bit selects and latches it. From then on one shared counter times every strobe, so later changes on the configuration inputs do not affect the access in flight. The block does not check that a setup and width fit within the total length. Instead, the end of the access always forces every strobe high.

Top module: `smem_strobe_gen`

## Requirements
- R1: A setup code s[5:0] decodes to 128*s[5] + s[4:0] clocks. Access clock index 0 is the first clock after the start request is sampled. A strobe goes low at index equal to its decoded setup.
- R2: A width code p[6:0] decodes to 256*p[6] + p[5:0] clocks. A strobe stays low for every index i with setup <= i < setup + width, and is high at all other indices.
- R3: A length code c[8:0] decodes to 256*c[8:7] + c[6:0] clocks; a code that decodes to zero counts as one clock. The access lasts that many clocks, and done_o is high only in its last clock.
- R4: With dir_i = 0 (read), rd_n_o follows the read-strobe pair, cs_n_o follows the read chip-select pair, the read length applies, and wr_n_o stays high. With dir_i = 1 (write), wr_n_o follows the write-strobe pair, cs_n_o follows the write chip-select pair, the write length applies, and rd_n_o stays high.
- R5: When setup plus width runs past the access length, the strobe is high from the clock after the last access clock onward.
- R6: A width code that decodes to zero leaves that strobe high for the whole access.
- R7: A start request while an access is in progress is ignored, including in the done clock. Direction and codes are taken only when a request is accepted, so later changes to them do not affect the running access.
- R8: After reset all strobes are high, and busy_o and done_o are low.
- R9: busy_o is high for exactly the access clocks. A start request held high continuously yields back-to-back accesses separated by exactly one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access request, sampled when idle |
| dir_i | input | 1 | 0 = read, 1 = write |
| rd_stb_setup_i | input | 6 | Read strobe setup code |
| rd_stb_width_i | input | 7 | Read strobe width code |
| rd_sel_setup_i | input | 6 | Chip-select setup code for reads |
| rd_sel_width_i | input | 7 | Chip-select width code for reads |
| wr_stb_setup_i | input | 6 | Write strobe setup code |
| wr_stb_width_i | input | 7 | Write strobe width code |
| wr_sel_setup_i | input | 6 | Chip-select setup code for writes |
| wr_sel_width_i | input | 7 | Chip-select width code for writes |
| rd_len_i | input | 9 | Read access length code |
| wr_len_i | input | 9 | Write access length code |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | High in the last clock of an access |

## Verification
Two events can fall in the same clock: the done clock of one access and a fresh start request. The bench provokes this in two ways. In one test it raises start in the last clock with the opposite direction and zeroed codes. In another it holds start high across several accesses. It then judges that the request is dropped, that busy_o falls for exactly one clock, and that the following access uses the values present at its own acceptance. A second collision is a strobe window that runs past the access length. The bench provokes it with a setup plus width larger than the length, and checks that the strobe returns high exactly when the access ends.

// File: rtl/smem_strobe_pkg.sv
package smem_strobe_pkg;

    localparam int SETUP_CW = 6;
    localparam int WIDTH_CW = 7;
    localparam int LEN_CW   = 9;
    localparam int CNT_W    = 10;
    localparam int N_CHAN   = 2;   // channel 0: data strobe, channel 1: chip select

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_t;

    typedef struct packed {
        logic [SETUP_CW-1:0] setup;
        logic [WIDTH_CW-1:0] width;
    } stb_code_t;

    typedef struct packed {
        cnt_t open_at;
        cnt_t close_at;   // first index at which the strobe is high again
    } stb_window_t;

    function automatic cnt_t decode_setup(input logic [SETUP_CW-1:0] c);
        return cnt_t'({c[SETUP_CW-1], 7'd0}) + cnt_t'(c[SETUP_CW-2:0]);
    endfunction

    function automatic cnt_t decode_width(input logic [WIDTH_CW-1:0] c);
        return cnt_t'({c[WIDTH_CW-1], 8'd0}) + cnt_t'(c[WIDTH_CW-2:0]);
    endfunction

    function automatic cnt_t decode_len(input logic [LEN_CW-1:0] c);
        return cnt_t'({c[LEN_CW-1:LEN_CW-2], 8'd0}) + cnt_t'(c[LEN_CW-3:0]);
    endfunction

endpackage

// File: rtl/smem_window_decode.sv
module smem_window_decode
    import smem_strobe_pkg::*;
(
    input  stb_code_t   code_i,
    output stb_window_t win_o
);
    cnt_t open_at;

    always_comb begin
        open_at        = decode_setup(code_i.setup);
        win_o.open_at  = open_at;
        win_o.close_at = open_at + decode_width(code_i.width);
    end
endmodule

// File: rtl/smem_cycle_ctr.sv
module smem_cycle_ctr
    import smem_strobe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  cnt_t last_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o,
    output cnt_t cnt_o
);
    logic busy_q;
    cnt_t cnt_q;

    assign accept_o = start_i && !busy_q;
    assign busy_o   = busy_q;
    assign cnt_o    = cnt_q;
    assign done_o   = busy_q && (cnt_q == last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            busy_q <= start_i;
            cnt_q  <= '0;
        end else if (cnt_q == last_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + cnt_t'(1);
        end
    end

    // R9: the done clock is always the last busy clock
    a_r9_done_ends: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R3: the counter never runs past the final index
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (cnt_o <= last_i));

    // R7: a running access advances by one and is not restarted
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> (busy_o && cnt_o == $past(cnt_o) + cnt_t'(1)));
endmodule

// File: rtl/smem_strobe_win.sv
module smem_strobe_win
    import smem_strobe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy_i,
    input  cnt_t        cnt_i,
    input  stb_window_t win_i,
    output logic        act_n_o
);
    logic in_win;

    assign in_win  = (cnt_i >= win_i.open_at) && (cnt_i < win_i.close_at);
    assign act_n_o = !(busy_i && in_win);

    // R6: an empty window never drives the strobe low
    a_r6_empty_window: assert property (@(posedge clk) disable iff (rst)
        (win_i.open_at == win_i.close_at) |-> act_n_o);

    // R1: the strobe never falls before its setup index
    a_r1_not_early: assert property (@(posedge clk) disable iff (rst)
        !act_n_o |-> (cnt_i >= win_i.open_at));
endmodule

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen
    import smem_strobe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                dir_i,
    input  logic [SETUP_CW-1:0] rd_stb_setup_i,
    input  logic [WIDTH_CW-1:0] rd_stb_width_i,
    input  logic [SETUP_CW-1:0] rd_sel_setup_i,
    input  logic [WIDTH_CW-1:0] rd_sel_width_i,
    input  logic [SETUP_CW-1:0] wr_stb_setup_i,
    input  logic [WIDTH_CW-1:0] wr_stb_width_i,
    input  logic [SETUP_CW-1:0] wr_sel_setup_i,
    input  logic [WIDTH_CW-1:0] wr_sel_width_i,
    input  logic [LEN_CW-1:0]   rd_len_i,
    input  logic [LEN_CW-1:0]   wr_len_i,
    output logic                rd_n_o,
    output logic                wr_n_o,
    output logic                cs_n_o,
    output logic                busy_o,
    output logic                done_o
);
    stb_code_t   rd_code  [N_CHAN];
    stb_code_t   wr_code  [N_CHAN];
    stb_code_t   sel_code [N_CHAN];
    stb_window_t win_d    [N_CHAN];
    stb_window_t win_q    [N_CHAN];
    logic [N_CHAN-1:0] act_n;

    acc_kind_t kind_q;
    cnt_t      len_dec, last_d, last_q, cnt;
    logic      accept;

    assign rd_code[0] = '{setup: rd_stb_setup_i, width: rd_stb_width_i};
    assign rd_code[1] = '{setup: rd_sel_setup_i, width: rd_sel_width_i};
    assign wr_code[0] = '{setup: wr_stb_setup_i, width: wr_stb_width_i};
    assign wr_code[1] = '{setup: wr_sel_setup_i, width: wr_sel_width_i};

    assign len_dec = decode_len(dir_i ? wr_len_i : rd_len_i);
    assign last_d  = (len_dec == '0) ? '0 : len_dec - cnt_t'(1);

    smem_cycle_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .last_i   (last_q),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .cnt_o    (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= ACC_READ;
            last_q <= '0;
        end else if (accept) begin
            kind_q <= dir_i ? ACC_WRITE : ACC_READ;
            last_q <= last_d;
        end
    end

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        assign sel_code[g] = dir_i ? wr_code[g] : rd_code[g];

        smem_window_decode u_dec (
            .code_i (sel_code[g]),
            .win_o  (win_d[g])
        );

        always_ff @(posedge clk) begin
            if (rst)
                win_q[g] <= '0;
            else if (accept)
                win_q[g] <= win_d[g];
        end

        smem_strobe_win u_win (
            .clk     (clk),
            .rst     (rst),
            .busy_i  (busy_o),
            .cnt_i   (cnt),
            .win_i   (win_q[g]),
            .act_n_o (act_n[g])
        );
    end

    assign rd_n_o = act_n[0] || (kind_q == ACC_WRITE);
    assign wr_n_o = act_n[0] || (kind_q == ACC_READ);
    assign cs_n_o = act_n[1];

    // R4: read and write strobes never fall together
    a_r4_one_dir: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    // R5: outside an access every strobe is high
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (rd_n_o && wr_n_o && cs_n_o));

    // R7: the latched access settings hold for the whole access
    a_r7_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> ($stable(kind_q) && $stable(last_q)));
endmodule

// File: tb/smem_strobe_gen_bench.sv
`timescale 1ns/1ps
module smem_strobe_gen_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, dir = 1'b0;
    logic [5:0] rss = '0, rcs = '0, wss = '0, wcs = '0;
    logic [6:0] rsw = '0, rcw = '0, wsw = '0, wcw = '0;
    logic [8:0] rlen = '0, wlen = '0;
    logic rd_n, wr_n, cs_n, busy, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    smem_strobe_gen u_smem_strobe_gen (
        .clk(clk), .rst(rst), .start_i(start), .dir_i(dir),
        .rd_stb_setup_i(rss), .rd_stb_width_i(rsw),
        .rd_sel_setup_i(rcs), .rd_sel_width_i(rcw),
        .wr_stb_setup_i(wss), .wr_stb_width_i(wsw),
        .wr_sel_setup_i(wcs), .wr_sel_width_i(wcw),
        .rd_len_i(rlen), .wr_len_i(wlen),
        .rd_n_o(rd_n), .wr_n_o(wr_n), .cs_n_o(cs_n),
        .busy_o(busy), .done_o(done)
    );

    function automatic int f_setup(input logic [5:0] c);
        return (c[5] ? 128 : 0) + int'(c[4:0]);
    endfunction
    function automatic int f_width(input logic [6:0] c);
        return (c[6] ? 256 : 0) + int'(c[5:0]);
    endfunction
    function automatic int f_len(input logic [8:0] c);
        int v;
        v = 256 * int'(c[8:7]) + int'(c[6:0]);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {rd_n,wr_n,cs_n,busy,done} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One access; optional stray start (opposite direction, zeroed codes) at index hit
    task automatic run_access(input string tag, input logic d, input int hit);
        int s0, e0, s1, e1, n;
        s0 = d ? f_setup(wss) : f_setup(rss);
        e0 = s0 + (d ? f_width(wsw) : f_width(rsw));
        s1 = d ? f_setup(wcs) : f_setup(rcs);
        e1 = s1 + (d ? f_width(wcw) : f_width(rcw));
        n  = d ? f_len(wlen) : f_len(rlen);
        dir = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic ds, cs;
            ds = !(i >= s0 && i < e0);
            cs = !(i >= s1 && i < e1);
            check(tag, {rd_n, wr_n, cs_n, busy, done},
                  {d ? 1'b1 : ds, d ? ds : 1'b1, cs, 1'b1, i == n - 1});
            if (i == hit) begin
                start = 1'b1; dir = !d;
                {rss, rcs, wss, wcs} = '0; {rsw, rcw, wsw, wcw} = '0;
                {rlen, wlen} = '0;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check({tag, " end"}, {rd_n, wr_n, cs_n, busy, done}, 5'b11100);
    endtask

    task automatic t_reset();
        check("R8 reset", {rd_n, wr_n, cs_n, busy, done}, 5'b11100);
    endtask

    task automatic t_basic();
        rss = 6'd2; rsw = 7'd3; rcs = 6'd0; rcw = 7'd6; rlen = 9'd8;
        wss = 6'd1; wsw = 7'd1; wcs = 6'd4; wcw = 7'd2; wlen = 9'd5;
        run_access("R1/R2/R4 read basic", 1'b0, -1);
        run_access("R1/R2/R4 write basic", 1'b1, -1);
    endtask

    task automatic t_coarse();
        rss = 6'h21; rsw = 7'h42; rcs = 6'h20; rcw = 7'h40; rlen = 9'h181;
        run_access("R1/R2/R3 coarse read", 1'b0, -1);
        wss = 6'h3F; wsw = 7'h7F; wcs = 6'h1F; wcw = 7'h3F; wlen = 9'h1FF;
        run_access("R1/R2/R3 coarse write", 1'b1, -1);
        wss = 6'd5; wsw = 7'd9; wcs = 6'd0; wcw = 7'd1; wlen = 9'h0C3;
        run_access("R3 mid length range", 1'b1, -1);
    endtask

    task automatic t_overrun();
        rss = 6'd3; rsw = 7'd10; rcs = 6'd0; rcw = 7'h40; rlen = 9'd6;
        run_access("R5 window past length", 1'b0, -1);
    endtask

    task automatic t_zero();
        rss = 6'd1; rsw = 7'd0; rcs = 6'd0; rcw = 7'd0; rlen = 9'd4;
        run_access("R6 zero width", 1'b0, -1);
        wss = 6'd0; wsw = 7'd2; wcs = 6'd0; wcw = 7'd1; wlen = 9'd0;
        run_access("R3 zero length one clock", 1'b1, -1);
    endtask

    task automatic t_ignore();
        rss = 6'd1; rsw = 7'd4; rcs = 6'd0; rcw = 7'd7; rlen = 9'd7;
        run_access("R7 start mid access", 1'b0, 2);
        wss = 6'd2; wsw = 7'd2; wcs = 6'd1; wcw = 7'd4; wlen = 9'd6;
        run_access("R7 start in done clock", 1'b1, 5);
    endtask

    task automatic t_back_to_back();
        rss = 6'd0; rsw = 7'd1; rcs = 6'd0; rcw = 7'd2; rlen = 9'd3;
        dir = 1'b0; start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 11; k++) begin
            int ph;
            ph = k % 4;   // 0..2 busy indices, 3 idle
            check("R9 held start", {busy, done}, {ph != 3, ph == 2});
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        check("R9 idle after release", {rd_n, wr_n, cs_n, busy, done}, 5'b11100);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_coarse();
        t_overrun();
        t_zero();
        t_ignore();
        t_back_to_back();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule